// File: doc/BRIEF.md
# Queued Interrupt Identity Bank

This block collects single-cycle event pulses from a set of interrupt sources. Each source has one visible identity bit. Behind that bit is a one-entry back queue, so each source remembers up to two events. Software reads the identity bits, handles them, and clears them by writing ones. If a second event is waiting when a bit is cleared, the bit reads zero for one cycle and then sets itself again from the queue. Software therefore sees the remaining event as a fresh assertion.

An enable register selects which identity bits drive the single summary interrupt line. An idle output reports whether the bank is fully drained, meaning that no visible bit and no queued event remains. An event that arrives for a source that already holds two events is lost. The loss sets a sticky overflow flag, which software clears separately.

All writes use one port. The address field selects the target:
- 0: clear identity bits (write-one-to-clear).
- 1: load the enable register.
- 2: clear the overflow flag (bit 0, write-one-to-clear).
- 3: no target.

Top module: `qid_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every identity bit, queue entry, enable bit and the overflow flag read zero, so `ident_o`, `en_o`, `ovf_o` and `irq_o` are 0 and `idle_o` is 1.
- R2: A pulse on `evt_i[i]` with the bit clear and its queue empty makes `ident_o[i]` read 1 from the clock edge that samples the pulse.
- R3: A pulse on `evt_i[i]` while `ident_o[i]` is 1 and its queue is empty fills the queue and leaves `ident_o[i]` at 1.
- R4: A write to address 0 with `wr_data_i[i]`=1, while `ident_o[i]` is 1 and an event is queued, makes `ident_o[i]` read 0 for exactly the next cycle and 1 in the cycle after. The queue is then empty.
- R5: `idle_o` is 1 exactly when no identity bit is set and no event is queued.
- R6: In an address-0 write, a data bit of 0 leaves its identity bit unchanged, and a data bit of 1 clears a set bit.
- R7: An event for a source that holds both a visible and a queued event is dropped and sets `ovf_o`. `ovf_o` stays 1 until an address-2 write with data bit 0 set. If a drop and that clear happen in the same cycle, the drop wins.
- R8: An event in the same cycle as a clear of its bit is applied after the clear. It refills the visible bit when the visible bit is free, and otherwise it goes to the queue.
- R9: An address-1 write loads `en_o`. `irq_o` is 1 exactly when some bit is set in both `ident_o` and `en_o`.
- R10: A write to address 3, or any cycle with `wr_en_i` low, changes no identity bit, queue entry, enable bit or overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N | Event pulse per source |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write target: 0 identity clear, 1 enable, 2 overflow clear, 3 none |
| wr_data_i | input | N | Write data |
| ident_o | output | N | Visible identity bits |
| en_o | output | N | Enable register |
| ovf_o | output | 1 | Sticky overflow flag |
| idle_o | output | 1 | No visible or queued event remains |
| irq_o | output | 1 | Summary of enabled identity bits |

## Verification
The assertions assume that `evt_i`, `wr_en_i`, `wr_addr_i` and `wr_data_i` are sampled only at rising edges. They also assume that a level held on `evt_i[i]` over several cycles counts as one event per cycle. The refill checks look two cycles ahead, so they require that no second clear of the same bit falls into the gap cycle. Those properties are written to allow for that case, and the stimulus still produces clears in gap cycles, which the reference model covers. The bench drives every input half a period away from the sampling edge. It mixes directed sequences for stacking, refill, overflow and collisions with a random phase in which events and all four write targets are dense.

// File: rtl/qid_pkg.sv
package qid_pkg;
  typedef enum logic [1:0] {
    QID_A_CLEAR  = 2'd0,
    QID_A_ENABLE = 2'd1,
    QID_A_OVFCLR = 2'd2,
    QID_A_NONE   = 2'd3
  } qid_addr_e;
endpackage

// File: rtl/qid_slot.sv
module qid_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic vis_o,
  output logic que_o,
  output logic drop_o
);
  logic vis_q, que_q;
  logic vis_d, que_d, upd;

  always_comb begin
    vis_d = vis_q & ~clr_i;
    que_d = que_q;
    // refill from the back queue one cycle after a clear
    if (!vis_q && que_q) begin
      vis_d = 1'b1;
      que_d = 1'b0;
    end
    drop_o = 1'b0;
    if (evt_i) begin
      if (!vis_d)      vis_d  = 1'b1;
      else if (!que_d) que_d  = 1'b1;
      else             drop_o = 1'b1;
    end
    upd = evt_i | clr_i | (!vis_q && que_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= 1'b0;
      que_q <= 1'b0;
    end else if (upd) begin
      vis_q <= vis_d;
      que_q <= que_d;
    end
  end

  assign vis_o = vis_q;
  assign que_o = que_q;
endmodule

// File: rtl/qid_ctrl.sv
module qid_ctrl
  import qid_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [N-1:0] wr_data_i,
  input  logic [N-1:0] drop_i,
  output logic [N-1:0] clr_o,
  output logic [N-1:0] en_o,
  output logic         ovf_o
);
  logic [N-1:0] en_q;
  logic         ovf_q, ovf_d;
  logic         en_we, ovf_we;
  qid_addr_e    addr;

  always_comb begin
    addr   = qid_addr_e'(wr_addr_i);
    clr_o  = (wr_en_i && addr == QID_A_CLEAR) ? wr_data_i : '0;
    en_we  = wr_en_i && addr == QID_A_ENABLE;
    ovf_d  = ovf_q;
    if (wr_en_i && addr == QID_A_OVFCLR && wr_data_i[0]) ovf_d = 1'b0;
    if (|drop_i) ovf_d = 1'b1;
    ovf_we = ovf_d != ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_we) ovf_q <= ovf_d;
  end

  assign en_o  = en_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/qid_bank.sv
module qid_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] ident_o,
  output logic [N-1:0] en_o,
  output logic         ovf_o,
  output logic         idle_o,
  output logic         irq_o
);
  logic [N-1:0] clr_vec, vis_vec, que_vec, drop_vec;

  qid_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .drop_i(drop_vec), .clr_o(clr_vec),
    .en_o(en_o), .ovf_o(ovf_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_src
    qid_slot u_slot (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i[i]), .clr_i(clr_vec[i]),
      .vis_o(vis_vec[i]), .que_o(que_vec[i]), .drop_o(drop_vec[i])
    );
  end

  assign ident_o = vis_vec;
  assign idle_o  = ~|(vis_vec | que_vec);
  assign irq_o   = |(vis_vec & en_o);
endmodule

// File: rtl/qid_chk.sv
module qid_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt_i,
  input logic         wr_en_i,
  input logic [1:0]   wr_addr_i,
  input logic [N-1:0] wr_data_i,
  input logic [N-1:0] ident_o,
  input logic [N-1:0] que,
  input logic         ovf_o,
  input logic         idle_o
);
  logic [N-1:0] clr;
  logic         ovf_clr;
  assign clr     = (wr_en_i && wr_addr_i == 2'd0) ? wr_data_i : '0;
  assign ovf_clr = wr_en_i && wr_addr_i == 2'd2 && wr_data_i[0];

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (ident_o == '0)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr) |=> ovf_o); // R7

  for (genvar i = 0; i < N; i++) begin : g_bit
    AST_QUEUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ident_o[i] && !que[i] && evt_i[i] && !clr[i]) |=> (ident_o[i] && que[i])); // R3
    AST_REFILL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && ident_o[i] && que[i] && !evt_i[i]) |=> !ident_o[i]); // R4
    AST_REFILL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr[i] && ident_o[i] && que[i], 2) && !$past(clr[i])) |-> ident_o[i]); // R4
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ident_o[i]) |-> ($past(evt_i[i]) || $past(que[i]))); // R2
  end
endmodule

bind qid_bank qid_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ident_o(ident_o),
  .que(que_vec), .ovf_o(ovf_o), .idle_o(idle_o)
);

// File: tb/tb_qid_bank.sv
module tb_qid_bank;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt_i = '0, wr_data_i = '0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [N-1:0] ident_o, en_o;
  logic ovf_o, idle_o, irq_o;

  int tests = 0, fails = 0;
  int cnt [N];
  bit gap [N];
  logic [N-1:0] men;
  bit movf;

  always #10 clk = ~clk;

  qid_bank #(.N(N)) dut (.*);

  function automatic logic [N-1:0] m_ident();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (cnt[i] > 0) && !gap[i];
    return r;
  endfunction

  function automatic bit m_idle();
    for (int i = 0; i < N; i++) if (cnt[i] != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk1(string tag, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk1(tag, "ident", ident_o, m_ident());
    chk1(tag, "en R9", en_o, men);
    chk1(tag, "ovf R7", ovf_o, movf);
    chk1(tag, "idle R5", idle_o, m_idle());
    chk1(tag, "irq R9", irq_o, |(m_ident() & men));
  endtask

  // drives at a falling edge, advances the model, then compares one cycle later
  task automatic step(logic [N-1:0] e, bit we, logic [1:0] a, logic [N-1:0] d, string tag);
    bit dropped = 0;
    evt_i = e; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    for (int i = 0; i < N; i++) begin
      bit vis = (cnt[i] > 0) && !gap[i];
      if (we && a == 2'd0 && d[i] && vis) begin
        cnt[i]--;
        gap[i] = cnt[i] > 0;
      end else if (gap[i]) gap[i] = 0;
      if (e[i]) begin
        if (cnt[i] < 2) begin
          cnt[i]++;
          gap[i] = 0;
        end else dropped = 1;
      end
    end
    if (we && a == 2'd1) men = d;
    if (we && a == 2'd2 && d[0]) movf = 0;
    if (dropped) movf = 1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin cnt[i] = 0; gap[i] = 0; end
    men = '0; movf = 0;
    @(negedge clk);
    compare("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");
    step(8'h01, 0, 0, 0, "R2 first event");
    step(8'h01, 0, 0, 0, "R3 second event queued");
    step(8'h00, 1, 0, 8'h00, "R6 zero write keeps bit");
    step(8'h00, 1, 0, 8'h01, "R4 gap cycle");
    chk1("R4", "gap bit", ident_o[0], 0);
    step(8'h00, 0, 0, 0, "R4 refill");
    chk1("R4", "refill bit", ident_o[0], 1);
    step(8'h00, 1, 0, 8'h01, "R6 clear drains");
    chk1("R5", "idle after drain", idle_o, 1);
    step(8'h02, 0, 0, 0, "R2 bit1");
    step(8'h02, 0, 0, 0, "R3 bit1 queue");
    step(8'h02, 0, 0, 0, "R7 drop");
    chk1("R7", "overflow set", ovf_o, 1);
    step(8'h00, 1, 2'd3, 8'hFF, "R10 addr3 ignored");
    step(8'h00, 0, 2'd2, 8'hFF, "R10 strobe low ignored");
    step(8'h02, 1, 2'd2, 8'h01, "R7 drop beats clear");
    step(8'h00, 1, 2'd2, 8'h01, "R7 overflow cleared");
    step(8'h02, 1, 0, 8'h02, "R8 clear with event, queue full");
    step(8'h00, 1, 0, 8'h02, "R8 clear");
    step(8'h02, 1, 0, 8'h02, "R8 event in refill cycle");
    step(8'h00, 1, 1, 8'h06, "R9 enable write");
    chk1("R9", "irq on", irq_o, 1);
    step(8'h00, 1, 1, 8'h01, "R9 masked");
    chk1("R9", "irq off", irq_o, 0);
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] e = N'($urandom) & N'($urandom);
      bit we = $urandom_range(0, 1);
      step(e, we, 2'($urandom), N'($urandom), "R8 random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule